// File: doc/BRIEF.md
# Operand Address Generation Unit

This unit turns the 6-bit operand-mode field of a 16-bit-opcode processor into an operand location. It splits the field into a 3-bit mode and a 3-bit register number. It reads base and index values from an outside 16-entry register file. The file holds eight data registers at indices 0-7 and eight address registers at indices 8-15, and the unit reads it through two combinational read ports. It pulls 16-bit extension words from the instruction stream over a valid/ready handshake and advances a program counter by 2 for each word taken. It produces one of three results: the final 32-bit address, an immediate value, or a register index.

Auto-increment and auto-decrement modes produce a one-cycle writeback of the updated address register. Every completed request also reports the extra bus cycles that its mode and size cost. One request runs at a time. `start` is accepted only while the unit is idle, and the result is presented together with a one-cycle `done` strobe.

Size encoding used throughout: 0 = byte, 1 = word, 2 or 3 = long.

Top module: `operand_addr_unit`

## Requirements
- R1: Modes 0x00-0x0F are register direct. On these modes:
  - `is_reg` is 1 and `ea_addr` is the register-file index `{28'b0, mode[3:0]}`.
  - No extension word is fetched and `cycles` is 0.
- R2: Mode 0x10+n reads address register An (file index 8+n). `ea_addr` is An's value, and `cycles` is 4 (byte/word) or 8 (long).
- R3: Mode 0x18+n returns the old value of An as `ea_addr`. It writes back An+step with `wb_idx`=8+n.
  - The step is 1, 2 or 4 for byte, word or long.
  - When n=7 and the size is byte, the step is 2.
  - `cycles` is 4 or 8.
- R4: Mode 0x20+n subtracts the step before use. Both `ea_addr` and the written-back value are An-step. `cycles` is 6 or 10.
- R5: Mode 0x28+n takes An plus the sign-extended 16-bit extension word. Mode 0x38 is the sign-extended word alone. Both cost 8 or 12 cycles.
- R6: Mode 0x30+n decodes one extension word:
  - Bits 15:12 select the index register (0-15).
  - Bit 11 = 0 uses the index's sign-extended low 16 bits; bit 11 = 1 uses all 32 bits.
  - Bits 7:0 are a signed displacement.
  - The address is An + index + displacement, and `cycles` is 10 or 14.
- R7: Mode 0x39 takes two words, the first forming bits 31:16, and costs 12 or 16 cycles. Mode 0x3C is immediate:
  - Long takes two words, high word first.
  - Word is `{16'b0, w}` and byte is `{24'b0, w[7:0]}`.
  - `cycles` is 4 or 8.
- R8: Modes 0x3A and 0x3B use `pc_in` (the PC when the first word is fetched), truncated to 24 bits and sign-extended. 0x3A adds a signed 16-bit word; 0x3B adds an index word decoded as in R6. Costs are 8/12 and 10/14. In every mode, `pc_out` at `done` equals `pc_in` plus 2 per word taken.
- R9: Modes 0x3D-0x3F complete with `illegal`=1, no fetch, no writeback and `cycles`=0. Mode 0x3C sets `no_write`=1; all other legal modes set it to 0.
- R10: A word is taken only in a cycle where both `ext_valid` and `ext_ready` are high. While the unit waits for a word, `done` stays low.
- R11: `done` is a one-cycle pulse, and `wb_en` is high only together with `done`. After reset, `done`, `wb_en`, `illegal` and `ext_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a request (taken when idle) |
| ea_mode | input | 6 | Mode (5:3) and register (2:0) field |
| size | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| pc_in | input | 32 | PC just after the opcode |
| ext_valid | input | 1 | Extension word available |
| ext_data | input | 16 | Extension word |
| ext_ready | output | 1 | Unit accepts an extension word |
| rf_idx_a | output | 4 | Base register read index |
| rf_data_a | input | 32 | Base register value |
| rf_idx_b | output | 4 | Index register read index |
| rf_data_b | input | 32 | Index register value |
| ea_addr | output | 32 | Address, immediate or register index |
| is_reg | output | 1 | Result is a register index |
| wb_en | output | 1 | Address register writeback strobe |
| wb_idx | output | 4 | Writeback register index |
| wb_value | output | 32 | Writeback value |
| cycles | output | 5 | Extra bus cycles for the mode |
| no_write | output | 1 | Operand location is not writable |
| illegal | output | 1 | Mode is not defined |
| pc_out | output | 32 | PC after extension words |
| done | output | 1 | Result valid strobe |

## Verification
The assertions check the following on every cycle:
- the one-cycle shape of `done`;
- that `wb_en` appears only with `done` and always targets an address register;
- that illegal results carry no writeback and zero cost;
- that register-direct results cost nothing;
- that each accepted extension word advances `pc_out` by exactly 2.

The address arithmetic needs the bench's scenarios, since it depends on register contents and extension words. This covers sign extension of displacements and index words, the byte step of 2 on A7, the PC truncation to 24 bits, and the order in which words are assembled. The same holds for the per-mode cycle table and for correct behaviour across stalled handshakes.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    MC_DREG, MC_AREG, MC_IND, MC_POST, MC_PRE, MC_DISP, MC_INDEX,
    MC_ABSW, MC_ABSL, MC_PCDISP, MC_PCINDEX, MC_IMM, MC_BAD
  } mode_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH1, ST_FETCH2, ST_CALC, ST_DONE
  } ea_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  function automatic mode_cls_e classify(input logic [5:0] m);
    mode_cls_e c;
    case (m[5:3])
      3'd0: c = MC_DREG;
      3'd1: c = MC_AREG;
      3'd2: c = MC_IND;
      3'd3: c = MC_POST;
      3'd4: c = MC_PRE;
      3'd5: c = MC_DISP;
      3'd6: c = MC_INDEX;
      default: begin
        case (m[2:0])
          3'd0: c = MC_ABSW;
          3'd1: c = MC_ABSL;
          3'd2: c = MC_PCDISP;
          3'd3: c = MC_PCINDEX;
          3'd4: c = MC_IMM;
          default: c = MC_BAD;
        endcase
      end
    endcase
    return c;
  endfunction

  // Auto-modify step; the stack register never goes to an odd address.
  function automatic logic [2:0] step_of(input logic [1:0] sz, input logic is_sp);
    logic [2:0] s;
    if (sz == SZ_BYTE)      s = is_sp ? 3'd2 : 3'd1;
    else if (sz == SZ_WORD) s = 3'd2;
    else                    s = 3'd4;
    return s;
  endfunction

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
#(
  parameter int CYC_W = 5
) (
  input  logic [5:0]       mode,
  input  logic [1:0]       size,
  output mode_cls_e        cls,
  output logic [1:0]       n_words,
  output logic [CYC_W-1:0] cost,
  output logic             bad,
  output logic             ro
);
  localparam logic [CYC_W-1:0] LONG_EXTRA = CYC_W'(4);

  logic             is_long;
  logic [CYC_W-1:0] base_cost;

  always_comb begin
    cls     = classify(mode);
    is_long = size[1];
    bad     = (cls == MC_BAD);
    ro      = (cls == MC_IMM);
    case (cls)
      MC_DISP, MC_INDEX, MC_ABSW, MC_PCDISP, MC_PCINDEX: n_words = 2'd1;
      MC_ABSL: n_words = 2'd2;
      MC_IMM:  n_words = is_long ? 2'd2 : 2'd1;
      default: n_words = 2'd0;
    endcase
    case (cls)
      MC_IND, MC_POST, MC_IMM:          base_cost = CYC_W'(4);
      MC_PRE:                           base_cost = CYC_W'(6);
      MC_DISP, MC_ABSW, MC_PCDISP:      base_cost = CYC_W'(8);
      MC_INDEX, MC_PCINDEX:             base_cost = CYC_W'(10);
      MC_ABSL:                          base_cost = CYC_W'(12);
      default:                          base_cost = '0;
    endcase
    if (base_cost != '0 && is_long) cost = base_cost + LONG_EXTRA;
    else                            cost = base_cost;
  end
endmodule

// File: rtl/ea_ext_capture.sv
module ea_ext_capture #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int PC_SIG = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              take,
  input  logic              second,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] w1,
  output logic [WORD_W-1:0] w2,
  output logic [PC_SIG-1:0] pc_base,
  output logic [ADDR_W-1:0] pc_cur
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(WORD_W / 8);

  logic              w1_en, w2_en, pc_en;
  logic [ADDR_W-1:0] pc_d;

  always_comb begin
    w1_en = take && !second;
    w2_en = take && second;
    pc_en = load || take;
    pc_d  = load ? pc_in : pc_cur + PC_STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1      <= '0;
      w2      <= '0;
      pc_base <= '0;
      pc_cur  <= '0;
    end else begin
      if (w1_en) w1 <= data;
      if (w2_en) w2 <= data;
      if (load)  pc_base <= pc_in[PC_SIG-1:0];
      if (pc_en) pc_cur <= pc_d;
    end
  end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int PC_SIG = 24
) (
  input  mode_cls_e         cls,
  input  logic [3:0]        reg_code,
  input  logic [1:0]        size,
  input  logic [WORD_W-1:0] w1,
  input  logic [WORD_W-1:0] w2,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [PC_SIG-1:0] pc_base,
  output logic [ADDR_W-1:0] addr,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_val
);
  localparam int DISP8_W = 8;

  logic [ADDR_W-1:0] disp16, disp8, idx_term, pc_ext, step, dec_val;

  always_comb begin
    disp16   = {{(ADDR_W-WORD_W){w1[WORD_W-1]}}, w1};
    disp8    = {{(ADDR_W-DISP8_W){w1[DISP8_W-1]}}, w1[DISP8_W-1:0]};
    idx_term = w1[11] ? index_val
                      : {{(ADDR_W-WORD_W){index_val[WORD_W-1]}}, index_val[WORD_W-1:0]};
    pc_ext   = {{(ADDR_W-PC_SIG){pc_base[PC_SIG-1]}}, pc_base};
    step     = ADDR_W'(step_of(size, reg_code[2:0] == 3'd7));
    dec_val  = base_val - step;
    wb_req   = 1'b0;
    wb_val   = base_val + step;
    case (cls)
      MC_DREG, MC_AREG: addr = ADDR_W'(reg_code);
      MC_IND:     addr = base_val;
      MC_POST: begin
        addr   = base_val;
        wb_req = 1'b1;
      end
      MC_PRE: begin
        addr   = dec_val;
        wb_val = dec_val;
        wb_req = 1'b1;
      end
      MC_DISP:    addr = base_val + disp16;
      MC_INDEX:   addr = base_val + idx_term + disp8;
      MC_ABSW:    addr = disp16;
      MC_ABSL:    addr = {w1, w2};
      MC_PCDISP:  addr = pc_ext + disp16;
      MC_PCINDEX: addr = pc_ext + idx_term + disp8;
      MC_IMM: begin
        if (size[1])           addr = {w1, w2};
        else if (size == SZ_WORD) addr = ADDR_W'(w1);
        else                   addr = ADDR_W'(w1[7:0]);
      end
      default:    addr = '0;
    endcase
  end
endmodule

// File: rtl/operand_addr_unit.sv
module operand_addr_unit
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int PC_SIG = 24,
  parameter int CYC_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [5:0]        ea_mode,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              ext_valid,
  input  logic [WORD_W-1:0] ext_data,
  output logic              ext_ready,
  output logic [3:0]        rf_idx_a,
  input  logic [ADDR_W-1:0] rf_data_a,
  output logic [3:0]        rf_idx_b,
  input  logic [ADDR_W-1:0] rf_data_b,
  output logic [ADDR_W-1:0] ea_addr,
  output logic              is_reg,
  output logic              wb_en,
  output logic [3:0]        wb_idx,
  output logic [ADDR_W-1:0] wb_value,
  output logic [CYC_W-1:0]  cycles,
  output logic              no_write,
  output logic              illegal,
  output logic [ADDR_W-1:0] pc_out,
  output logic              done
);
  ea_state_e state_q, state_d;
  logic [5:0] mode_q, mode_sel;
  logic [1:0] size_q, size_sel;
  logic       accept, take, calc_en;

  mode_cls_e        cls;
  logic [1:0]       n_words;
  logic [CYC_W-1:0] cost;
  logic             bad, ro;

  logic [WORD_W-1:0] w1, w2;
  logic [PC_SIG-1:0] pc_base;
  logic [ADDR_W-1:0] calc_addr, calc_wb;
  logic              calc_wb_req;

  logic [ADDR_W-1:0] addr_q, wbv_q;
  logic [CYC_W-1:0]  cyc_q;
  logic              reg_q, wbr_q, bad_q, ro_q;

  always_comb begin
    accept   = (state_q == ST_IDLE) && start;
    mode_sel = (state_q == ST_IDLE) ? ea_mode : mode_q;
    size_sel = (state_q == ST_IDLE) ? size : size_q;
    ext_ready = (state_q == ST_FETCH1) || (state_q == ST_FETCH2);
    take     = ext_ready && ext_valid;
    calc_en  = (state_q == ST_CALC);
    rf_idx_a = {1'b1, mode_q[2:0]};
    rf_idx_b = w1[WORD_W-1 -: 4];
  end

  ea_mode_decode #(.CYC_W(CYC_W)) u_dec (
    .mode(mode_sel), .size(size_sel), .cls(cls), .n_words(n_words),
    .cost(cost), .bad(bad), .ro(ro)
  );

  ea_ext_capture #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PC_SIG(PC_SIG)) u_ext (
    .clk(clk), .rst_n(rst_n), .load(accept), .pc_in(pc_in), .take(take),
    .second(state_q == ST_FETCH2), .data(ext_data), .w1(w1), .w2(w2),
    .pc_base(pc_base), .pc_cur(pc_out)
  );

  ea_addr_calc #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PC_SIG(PC_SIG)) u_calc (
    .cls(cls), .reg_code(mode_q[3:0]), .size(size_q), .w1(w1), .w2(w2),
    .base_val(rf_data_a), .index_val(rf_data_b), .pc_base(pc_base),
    .addr(calc_addr), .wb_req(calc_wb_req), .wb_val(calc_wb)
  );

  // Next-state process
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) begin
        if (bad || n_words == 2'd0) state_d = ST_CALC;
        else                        state_d = ST_FETCH1;
      end
      ST_FETCH1: if (ext_valid) state_d = (n_words == 2'd2) ? ST_FETCH2 : ST_CALC;
      ST_FETCH2: if (ext_valid) state_d = ST_CALC;
      ST_CALC:   state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      size_q  <= '0;
      addr_q  <= '0;
      wbv_q   <= '0;
      cyc_q   <= '0;
      reg_q   <= 1'b0;
      wbr_q   <= 1'b0;
      bad_q   <= 1'b0;
      ro_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mode_q <= ea_mode;
        size_q <= size;
      end
      if (calc_en) begin
        addr_q <= bad ? '0 : calc_addr;
        wbv_q  <= calc_wb;
        cyc_q  <= cost;
        reg_q  <= (cls == MC_DREG) || (cls == MC_AREG);
        wbr_q  <= calc_wb_req && !bad;
        bad_q  <= bad;
        ro_q   <= ro;
      end
    end
  end

  always_comb begin
    done     = (state_q == ST_DONE);
    wb_en    = done && wbr_q;
    wb_idx   = {1'b1, mode_q[2:0]};
    wb_value = wbv_q;
    ea_addr  = addr_q;
    is_reg   = reg_q;
    cycles   = cyc_q;
    illegal  = done && bad_q;
    no_write = ro_q;
  end
endmodule

// File: rtl/operand_addr_unit_chk.sv
module operand_addr_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int CYC_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              ext_ready,
  input logic              ext_valid,
  input logic              wb_en,
  input logic [3:0]        wb_idx,
  input logic              illegal,
  input logic              is_reg,
  input logic [CYC_W-1:0]  cycles,
  input logic [ADDR_W-1:0] pc_out
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done); // R11
  AST_WB_AREG: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_idx[3]); // R3
  AST_NO_FETCH_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ext_ready); // R10
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wb_en && cycles == '0)); // R9
  AST_REG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_reg) |-> cycles == '0); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_valid && ext_ready) |=> pc_out == $past(pc_out) + ADDR_W'(2)); // R8
endmodule

bind operand_addr_unit operand_addr_unit_chk #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .ext_ready(ext_ready),
  .ext_valid(ext_valid), .wb_en(wb_en), .wb_idx(wb_idx), .illegal(illegal),
  .is_reg(is_reg), .cycles(cycles), .pc_out(pc_out)
);

// File: tb/operand_addr_unit_bench.sv
module operand_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  ea_mode = '0;
  logic [1:0]  size = '0;
  logic [31:0] pc_in = '0;
  logic        ext_valid = 1'b0;
  logic [15:0] ext_data = '0;
  logic        ext_ready;
  logic [3:0]  rf_idx_a, rf_idx_b;
  logic [31:0] rf_data_a, rf_data_b;
  logic [31:0] ea_addr, wb_value, pc_out;
  logic        is_reg, wb_en, no_write, illegal, done;
  logic [3:0]  wb_idx;
  logic [4:0]  cycles;

  int errors = 0;
  int checks = 0;

  logic [31:0] rf_m [16];

  typedef struct {
    string       tag;
    logic [31:0] addr;
    logic        is_reg;
    logic        wb;
    logic [3:0]  wb_idx;
    logic [31:0] wb_val;
    logic [4:0]  cyc;
    logic        ill;
    logic        ro;
    logic [31:0] pc;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  assign rf_data_a = rf_m[rf_idx_a];
  assign rf_data_b = rf_m[rf_idx_b];

  operand_addr_unit u_operand_addr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .ea_mode(ea_mode), .size(size),
    .pc_in(pc_in), .ext_valid(ext_valid), .ext_data(ext_data),
    .ext_ready(ext_ready), .rf_idx_a(rf_idx_a), .rf_data_a(rf_data_a),
    .rf_idx_b(rf_idx_b), .rf_data_b(rf_data_b), .ea_addr(ea_addr),
    .is_reg(is_reg), .wb_en(wb_en), .wb_idx(wb_idx), .wb_value(wb_value),
    .cycles(cycles), .no_write(no_write), .illegal(illegal), .pc_out(pc_out),
    .done(done)
  );

  always @(posedge clk) if (wb_en) rf_m[wb_idx] <= wb_value;

  function automatic logic [31:0] sx16(input logic [15:0] w);
    return {{16{w[15]}}, w};
  endfunction

  function automatic logic [31:0] ix_val(input logic [15:0] w);
    logic [31:0] x;
    x = w[11] ? rf_m[w[15:12]] : sx16(rf_m[w[15:12]][15:0]);
    return x + {{24{w[7]}}, w[7:0]};
  endfunction

  function automatic int words_of(input logic [5:0] m, input logic [1:0] s);
    if (m >= 6'h28 && m <= 6'h38) return 1;
    if (m == 6'h39) return 2;
    if (m == 6'h3A || m == 6'h3B) return 1;
    if (m == 6'h3C) return (s >= 2) ? 2 : 1;
    return 0;
  endfunction

  function automatic exp_t model(input string tag, input logic [5:0] m,
      input logic [1:0] s, input logic [31:0] pc,
      input logic [15:0] w1, input logic [15:0] w2);
    exp_t e;
    logic [31:0] an, st, pcx;
    int lg;
    lg     = (s >= 2) ? 4 : 0;
    an     = rf_m[{1'b1, m[2:0]}];
    st     = (s == 0) ? ((m[2:0] == 3'd7) ? 2 : 1) : (s == 1) ? 2 : 4;
    pcx    = {{8{pc[23]}}, pc[23:0]};
    e.tag = tag; e.is_reg = 0; e.wb = 0; e.wb_idx = {1'b1, m[2:0]};
    e.wb_val = 0; e.ill = 0; e.ro = (m == 6'h3C); e.cyc = 0; e.addr = 0;
    e.pc = pc + 32'(2 * words_of(m, s));
    if (m < 6'h10) begin e.is_reg = 1; e.addr = {28'b0, m[3:0]}; end
    else if (m < 6'h18) begin e.addr = an; e.cyc = 5'(4 + lg); end
    else if (m < 6'h20) begin e.addr = an; e.wb = 1; e.wb_val = an + st; e.cyc = 5'(4 + lg); end
    else if (m < 6'h28) begin e.addr = an - st; e.wb = 1; e.wb_val = an - st; e.cyc = 5'(6 + lg); end
    else if (m < 6'h30) begin e.addr = an + sx16(w1); e.cyc = 5'(8 + lg); end
    else if (m < 6'h38) begin e.addr = an + ix_val(w1); e.cyc = 5'(10 + lg); end
    else if (m == 6'h38) begin e.addr = sx16(w1); e.cyc = 5'(8 + lg); end
    else if (m == 6'h39) begin e.addr = {w1, w2}; e.cyc = 5'(12 + lg); end
    else if (m == 6'h3A) begin e.addr = pcx + sx16(w1); e.cyc = 5'(8 + lg); end
    else if (m == 6'h3B) begin e.addr = pcx + ix_val(w1); e.cyc = 5'(10 + lg); end
    else if (m == 6'h3C) begin
      e.addr = (s >= 2) ? {w1, w2} : (s == 1) ? {16'b0, w1} : {24'b0, w1[7:0]};
      e.cyc = 5'(4 + lg);
    end else begin e.ill = 1; end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each done strobe
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) chk("R11", 32'(done), 32'd0, "unexpected done");
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, ea_addr, e.addr, "ea_addr");
        chk(e.tag, 32'(is_reg), 32'(e.is_reg), "is_reg");
        chk(e.tag, 32'(wb_en), 32'(e.wb), "wb_en");
        if (e.wb) begin
          chk(e.tag, 32'(wb_idx), 32'(e.wb_idx), "wb_idx");
          chk(e.tag, wb_value, e.wb_val, "wb_value");
        end
        chk(e.tag, 32'(cycles), 32'(e.cyc), "cycles");
        chk(e.tag, 32'(illegal), 32'(e.ill), "illegal");
        if (!e.ill) chk(e.tag, 32'(no_write), 32'(e.ro), "no_write");
        chk(e.tag, pc_out, e.pc, "pc_out");
      end
    end
  end

  // Driver: issue one request, feed its words, wait for completion
  task automatic run_op(input string tag, input logic [5:0] m, input logic [1:0] s,
      input logic [31:0] pc, input logic [15:0] w1, input logic [15:0] w2, input int stall);
    int nw;
    nw = (m > 6'h3C) ? 0 : words_of(m, s);
    @(negedge clk);
    sb.push_back(model(tag, m, s, pc, w1, w2));
    start = 1; ea_mode = m; size = s; pc_in = pc;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < nw; k++) begin
      for (int d = 0; d < stall; d++) begin
        chk("R10", {30'b0, ext_ready, done}, 32'h2, "stall ready/done");
        @(negedge clk);
      end
      ext_valid = 1; ext_data = (k == 0) ? w1 : w2;
      @(negedge clk);
      ext_valid = 0; ext_data = 16'hDEAD;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) rf_m[i] = 32'h1000_0000 + 32'(i * 'h11);
    rf_m[3] = 32'h1234_FFF0;
    rf_m[8] = 32'h0000_2000; rf_m[9] = 32'h0000_3000;
    rf_m[10] = 32'h8000_0010; rf_m[11] = 32'h0001_0000;
    for (int i = 12; i < 15; i++) rf_m[i] = 32'h0000_4000;
    rf_m[15] = 32'h0000_7F00;
    repeat (3) @(negedge clk);
    chk("R11", {28'b0, done, wb_en, illegal, ext_ready}, 32'h0, "reset strobes");
    rst_n = 1;
    @(negedge clk);
    chk("R11", {28'b0, done, wb_en, illegal, ext_ready}, 32'h0, "idle strobes");

    run_op("R1", 6'h03, 2, 32'h100, 0, 0, 0);
    run_op("R1", 6'h0A, 0, 32'h100, 0, 0, 0);
    run_op("R2", 6'h11, 1, 32'h100, 0, 0, 0);
    run_op("R2", 6'h11, 2, 32'h100, 0, 0, 0);
    run_op("R3", 6'h18, 0, 32'h100, 0, 0, 0);
    run_op("R3", 6'h1F, 0, 32'h100, 0, 0, 0);
    run_op("R3", 6'h19, 2, 32'h100, 0, 0, 0);
    run_op("R4", 6'h27, 0, 32'h100, 0, 0, 0);
    run_op("R4", 6'h22, 1, 32'h100, 0, 0, 0);
    run_op("R5", 6'h29, 1, 32'h200, 16'hFFFC, 0, 0);
    run_op("R5", 6'h38, 2, 32'h200, 16'h8000, 0, 3);
    run_op("R6", 6'h31, 1, 32'h200, 16'h30F0, 0, 0);
    run_op("R6", 6'h31, 2, 32'h200, 16'h3810, 0, 1);
    run_op("R7", 6'h39, 0, 32'h300, 16'h00AB, 16'hCDEF, 2);
    run_op("R7", 6'h3C, 2, 32'h300, 16'h1234, 16'h5678, 0);
    run_op("R7", 6'h3C, 1, 32'h300, 16'hBEEF, 0, 0);
    run_op("R7", 6'h3C, 0, 32'h300, 16'hBEEF, 0, 0);
    run_op("R8", 6'h3A, 1, 32'hFF80_0100, 16'h0010, 0, 0);
    run_op("R8", 6'h3B, 2, 32'h0012_0000, 16'h9880, 0, 1);
    run_op("R9", 6'h3D, 1, 32'h400, 0, 0, 0);
    run_op("R9", 6'h3F, 2, 32'h400, 0, 0, 0);
    @(negedge clk);
    chk("R11", 32'(done), 32'd0, "done is single pulse");
    chk("R11", 32'(sb.size()), 32'd0, "all results seen");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule